// File: doc/BRIEF.md
# QoS Register Mailbox with APB Access

This block is an APB slave with four 32-bit registers: an identification word, a configuration word, a command word and a data word. Software never addresses the internal QoS settings directly. It loads the data word, then writes a command that names a master port, an address channel and one of four setting kinds. The block runs that command against an internal bank that holds one setting set for each port and channel, and then drops its pending flag.

A read command copies the selected setting into the data word. A write command stores the data word into the selected setting. A soft-reset command returns the whole bank to zero. A command that names a port or setting kind that does not exist raises an error flag and changes nothing. While a command is pending, the command and data words are locked, and writes to them are dropped without any error response.

Top module: `qos_mailbox`

## Requirements
- R1: Offset 0x000 reads 0x3430322A and offset 0x004 reads 0x0090F105. This configuration word places slaves=9 in bits 24:20, ports=15 in bits 16:12, and sets bits 8, 2 and 0. APB writes to both offsets have no effect.
- R2: Every APB transfer completes with PREADY high and PSLVERR low. There are no wait states.
- R3: The command word at 0x008 has this layout: bit 31 pending, bit 30 direction (1 = write), bit 29 soft reset, bit 28 error, bits 11:8 port, bit 7 channel (1 = write-address channel), bits 2:0 setting kind. All other bits read as zero and ignore writes. After reset both 0x008 and 0x00C read 0.
- R4: Bit 31 is set by the write that accepts a command. It still reads 1 in the access phase that follows at once, and it reads 0 from two clocks after the accepting edge.
- R5: While bit 31 is 1, APB writes to 0x008 and 0x00C are dropped. The stored command fields and the data word keep their values.
- R6: A write command (bit 30 = 1) copies the data word into the setting selected by port, channel and kind (0..3). A read command copies that setting into 0x00C. Each combination of port, channel and kind is separate storage.
- R7: A command with bits 31 and 29 both set clears every setting to zero and raises no error, whatever the other fields hold.
- R8: A command with port 15 or kind 4..7 sets bit 28. It changes neither the bank nor the data word, and bit 31 still clears on time.
- R9: Bit 28 is cleared by any accepted APB write to 0x008.
- R10: After reset every setting reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| pslverr | output | 1 | APB error, always low |

## Verification
The hardest case to reach is an access that arrives while a command is still pending. A command is busy for only two clocks, and an APB write needs a setup phase plus an access phase. The bench therefore issues the next transfer back to back with the accepting write, so that its access edge lands on the last busy clock. An error command is chosen whose low kind bits alias a valid setting, so that a missing range check would show up as a changed stored value.

// File: rtl/qmb_pkg.sv
package qmb_pkg;

    localparam int DATA_W = 32;

    typedef struct packed {
        logic       en;
        logic       dir;
        logic       srst;
        logic       err;
        logic [3:0] port;
        logic       chan;
        logic [2:0] kind;
    } cmd_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_EXEC = 2'd1,
        SQ_DONE = 2'd2
    } sq_e;

    function automatic logic [DATA_W-1:0] cmd_word(cmd_t c);
        return {c.en, c.dir, c.srst, c.err, 16'h0000, c.port, c.chan, 4'h0, c.kind};
    endfunction

endpackage

// File: rtl/qmb_seq.sv
module qmb_seq
    import qmb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic exec,
    output logic fin
);

    sq_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            SQ_IDLE: if (start) state_d = SQ_EXEC;
            SQ_EXEC: state_d = SQ_DONE;
            SQ_DONE: state_d = SQ_IDLE;
            default: state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    assign exec = (state_q == SQ_EXEC);
    assign fin  = (state_q == SQ_DONE);

    AST_EXEC_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_EXEC) |=> (state_q == SQ_DONE)); // R4

endmodule

// File: rtl/qmb_bank.sv
module qmb_bank
    import qmb_pkg::*;
#(
    parameter int NUM_PORTS = 15,
    parameter int NUM_KINDS = 4,
    parameter int PORT_W    = 4,
    parameter int KIND_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [PORT_W-1:0] port,
    input  logic              chan,
    input  logic [KIND_W-1:0] kind,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int NUM_CH = 2;

    logic [DATA_W-1:0] mem_d [NUM_PORTS][NUM_CH][NUM_KINDS];
    logic [DATA_W-1:0] mem_q [NUM_PORTS][NUM_CH][NUM_KINDS];
    logic              sel_ok;

    assign sel_ok = (int'(port) < NUM_PORTS) && (int'(kind) < NUM_KINDS);

    always_comb begin
        mem_d = mem_q;
        for (int p = 0; p < NUM_PORTS; p++) begin
            for (int c = 0; c < NUM_CH; c++) begin
                for (int k = 0; k < NUM_KINDS; k++) begin
                    if (clr) begin
                        mem_d[p][c][k] = '0;
                    end else if (we && sel_ok && int'(port) == p
                                 && int'(chan) == c && int'(kind) == k) begin
                        mem_d[p][c][k] = wdata;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PORTS; p++)
                for (int c = 0; c < NUM_CH; c++)
                    for (int k = 0; k < NUM_KINDS; k++)
                        mem_q[p][c][k] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    always_comb begin
        rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++)
            for (int c = 0; c < NUM_CH; c++)
                for (int k = 0; k < NUM_KINDS; k++)
                    if (sel_ok && int'(port) == p && int'(chan) == c && int'(kind) == k)
                        rdata = mem_q[p][c][k];
    end

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (mem_q[0][0][0] == '0 && mem_q[NUM_PORTS-1][NUM_CH-1][NUM_KINDS-1] == '0)); // R7

endmodule

// File: rtl/qos_mailbox.sv
module qos_mailbox
    import qmb_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          NUM_PORTS = 15,
    parameter int          NUM_SLV   = 9,
    parameter logic [31:0] VERSION   = 32'h3430_322A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr
);

    localparam int          NUM_KINDS = 4;
    localparam logic [4:0]  SLV5      = 5'(NUM_SLV);
    localparam logic [4:0]  PRT5      = 5'(NUM_PORTS);
    localparam logic [31:0] CFG_WORD  = {7'h00, SLV5, 3'h0, PRT5, 3'h0, 9'b1_0000_0101};

    typedef struct packed {
        cmd_t              cmd;
        logic [DATA_W-1:0] data;
    } regs_t;

    regs_t             r_d, r_q;
    logic              acc_wr, hit, start, exec, fin, bad;
    logic              bank_clr, bank_we;
    logic [DATA_W-1:0] bank_rdata;
    logic [1:0]        sel;
    logic              unused_wbits;

    assign unused_wbits = ^{pwdata[27:12], pwdata[6:3]};
    assign sel    = paddr[3:2];
    assign hit    = (paddr[ADDR_W-1:4] == '0) && (paddr[1:0] == 2'b00);
    assign acc_wr = psel && penable && pwrite && hit;
    assign start  = acc_wr && (sel == 2'd2) && !r_q.cmd.en && pwdata[31];
    assign bad    = (int'(r_q.cmd.port) >= NUM_PORTS) || (int'(r_q.cmd.kind) >= NUM_KINDS);

    always_comb begin
        r_d      = r_q;
        bank_clr = 1'b0;
        bank_we  = 1'b0;
        if (acc_wr && !r_q.cmd.en) begin
            if (sel == 2'd2) begin
                r_d.cmd.en   = pwdata[31];
                r_d.cmd.dir  = pwdata[30];
                r_d.cmd.srst = pwdata[29];
                r_d.cmd.err  = 1'b0;
                r_d.cmd.port = pwdata[11:8];
                r_d.cmd.chan = pwdata[7];
                r_d.cmd.kind = pwdata[2:0];
            end else if (sel == 2'd3) begin
                r_d.data = pwdata;
            end
        end
        if (exec) begin
            if (r_q.cmd.srst)     bank_clr = 1'b1;
            else if (bad)         r_d.cmd.err = 1'b1;
            else if (r_q.cmd.dir) bank_we = 1'b1;
            else                  r_d.data = bank_rdata;
        end
        if (fin) r_d.cmd.en = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        prdata = '0;
        if (hit) begin
            case (sel)
                2'd0:    prdata = VERSION;
                2'd1:    prdata = CFG_WORD;
                2'd2:    prdata = cmd_word(r_q.cmd);
                default: prdata = r_q.data;
            endcase
        end
    end

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    qmb_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .exec  (exec),
        .fin   (fin)
    );

    qmb_bank #(
        .NUM_PORTS (NUM_PORTS),
        .NUM_KINDS (NUM_KINDS),
        .PORT_W    (4),
        .KIND_W    (3)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (bank_clr),
        .we    (bank_we),
        .port  (r_q.cmd.port),
        .chan  (r_q.cmd.chan),
        .kind  (r_q.cmd.kind),
        .wdata (r_q.data),
        .rdata (bank_rdata)
    );

    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.cmd.en) |=> r_q.cmd.en); // R4
    AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.cmd.en) |-> ##2 !r_q.cmd.en); // R4
    AST_FIELDS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cmd.en |=> $stable({r_q.cmd.dir, r_q.cmd.srst, r_q.cmd.port, r_q.cmd.chan, r_q.cmd.kind})); // R5
    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && sel == 2'd2 && !r_q.cmd.en) |=> !r_q.cmd.err); // R9
    AST_NO_CLR_ON_BAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !r_q.cmd.srst && bad) |=> $stable(r_q.data)); // R8

endmodule

// File: tb/qos_mailbox_bench.sv
`timescale 1ns/1ps
module qos_mailbox_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    int          total = 0;
    int          bad = 0;

    always #5 clk = ~clk;

    qos_mailbox u_qos_mailbox (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit en, input bit dir, input bit srst,
                                       input int port, input bit chan, input int kind);
        return {en, dir, srst, 1'b0, 16'h0, 4'(port), chan, 4'h0, 3'(kind)};
    endfunction

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        #1 chk("R2 write handshake", {30'h0, pready, pslverr}, 32'h2);
        @(posedge clk);
        #1 psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        chk("R2 read handshake", {30'h0, pready, pslverr}, 32'h2);
        @(posedge clk);
        #1 psel = 1'b0; penable = 1'b0;
    endtask

    task automatic run_cmd(input logic [31:0] c);
        apb_wr(12'h008, c);
        repeat (3) @(posedge clk);
    endtask

    task automatic put(input int port, input bit chan, input int kind, input logic [31:0] v);
        apb_wr(12'h00C, v);
        run_cmd(mk(1, 1, 0, port, chan, kind));
    endtask

    task automatic get(input int port, input bit chan, input int kind, output logic [31:0] v);
        run_cmd(mk(1, 0, 0, port, chan, kind));
        apb_rd(12'h00C, v);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        apb_rd(12'h000, v); chk("R1 id word", v, 32'h3430_322A);
        apb_rd(12'h004, v); chk("R1 cfg word", v, 32'h0090_F105);
        apb_rd(12'h008, v); chk("R3 cmd after reset", v, 32'h0);
        apb_rd(12'h00C, v); chk("R3 data after reset", v, 32'h0);
        get(14, 1, 3, v);   chk("R10 untouched setting", v, 32'h0);
    endtask

    task automatic t_readonly();
        logic [31:0] v;
        apb_wr(12'h000, 32'hFFFF_FFFF);
        apb_wr(12'h004, 32'h0);
        apb_rd(12'h000, v); chk("R1 id after write", v, 32'h3430_322A);
        apb_rd(12'h004, v); chk("R1 cfg after write", v, 32'h0090_F105);
        apb_wr(12'h008, 32'h7FFF_FFFF);
        apb_rd(12'h008, v); chk("R3 reserved bits masked", v, 32'h6000_0F87);
        apb_wr(12'h008, 32'h0);
    endtask

    task automatic t_timing();
        logic [31:0] v;
        apb_wr(12'h00C, 32'h0000_0011);
        apb_wr(12'h008, mk(1, 1, 0, 3, 0, 2));
        apb_rd(12'h008, v); chk("R4 pending next access", v[31], 1'b1);
        apb_rd(12'h008, v); chk("R4 pending cleared", v, mk(0, 1, 0, 3, 0, 2));
    endtask

    task automatic t_rw();
        logic [31:0] v;
        put(0, 0, 0, 32'hA000_0001);
        put(0, 1, 0, 32'hB000_0002);
        put(14, 0, 3, 32'hC000_0003);
        put(7, 1, 1, 32'hD000_0004);
        get(0, 0, 0, v);  chk("R6 port0 rd chan", v, 32'hA000_0001);
        get(0, 1, 0, v);  chk("R6 port0 wr chan", v, 32'hB000_0002);
        get(14, 0, 3, v); chk("R6 port14 kind3", v, 32'hC000_0003);
        get(7, 1, 1, v);  chk("R6 port7 kind1", v, 32'hD000_0004);
        get(3, 0, 2, v);  chk("R6 earlier write", v, 32'h0000_0011);
        get(7, 0, 1, v);  chk("R6 neighbour untouched", v, 32'h0);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        apb_wr(12'h00C, 32'h0000_AAAA);
        apb_wr(12'h008, mk(1, 1, 0, 5, 0, 0));
        apb_wr(12'h00C, 32'h0000_5555);
        repeat (2) @(posedge clk);
        apb_rd(12'h00C, v); chk("R5 data write dropped", v, 32'h0000_AAAA);
        apb_wr(12'h008, mk(1, 1, 0, 6, 1, 1));
        apb_wr(12'h008, mk(1, 0, 0, 9, 0, 2));
        repeat (2) @(posedge clk);
        apb_rd(12'h008, v); chk("R5 cmd write dropped", v, mk(0, 1, 0, 6, 1, 1));
        get(9, 0, 2, v); chk("R5 dropped cmd not run", v, 32'h0);
        get(5, 0, 0, v); chk("R5 locked cmd stored", v, 32'h0000_AAAA);
    endtask

    task automatic t_err();
        logic [31:0] v;
        apb_wr(12'h00C, 32'h1234_5678);
        run_cmd(mk(1, 1, 0, 0, 0, 4));
        apb_rd(12'h008, v); chk("R8 bad kind error", v, mk(0, 1, 0, 0, 0, 4) | 32'h1000_0000);
        apb_wr(12'h008, mk(0, 0, 0, 0, 0, 0));
        apb_rd(12'h008, v); chk("R9 error cleared", v[28], 1'b0);
        run_cmd(mk(1, 0, 0, 15, 0, 0));
        apb_rd(12'h008, v); chk("R8 bad port error", v, mk(0, 0, 0, 15, 0, 0) | 32'h1000_0000);
        apb_rd(12'h00C, v); chk("R8 data kept", v, 32'h1234_5678);
        get(0, 0, 0, v);    chk("R8 bank kept", v, 32'hA000_0001);
        apb_rd(12'h008, v); chk("R9 good cmd no error", v[28], 1'b0);
    endtask

    task automatic t_srst();
        logic [31:0] v;
        run_cmd(mk(1, 1, 1, 15, 1, 7));
        apb_rd(12'h008, v); chk("R7 no error on reset", v[28], 1'b0);
        get(0, 0, 0, v);  chk("R7 port0 cleared", v, 32'h0);
        get(14, 0, 3, v); chk("R7 port14 cleared", v, 32'h0);
        get(7, 1, 1, v);  chk("R7 port7 cleared", v, 32'h0);
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_readonly();
        t_timing();
        t_rw();
        t_lock();
        t_err();
        t_srst();
        repeat (2) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule